// File: doc/BRIEF.md
# Slotted Packet Framer with Transition Fill

This block builds fixed-length packets on a byte-wide transmit stream and sends one byte every clock cycle. A pulse on `slot_start` opens a packet. The packet carries, in this order: three preamble bytes, a start delimiter, a four-byte node address field, a payload region and a four-byte CRC-32 trailer. The CRC covers the address field and the payload region.

Between packets, and in every payload position that has no data, the line carries the alternating byte 0xAA. The line therefore never holds a static level, and a downstream clock recovery circuit stays locked. Payload bytes arrive through a valid/ready handshake. A flag marks the last byte of the data. The total packet length is read from a configuration input when each packet opens, so it can be changed between packets.

Top module: `pkt_framer`

## Requirements
- R1: While reset is asserted and directly after it is released, `tx_data` is 0xAA, and `tx_sof`, `pl_ready` and `busy` are 0. `start_err_cnt` is 0.
- R2: When no packet is being emitted, `tx_data` is 0xAA in every cycle, `tx_sof` is 0 and `busy` is 0.
- R3: A `slot_start` sampled while `busy` is 0 opens a packet. Its first byte appears on `tx_data` with `tx_sof`=1 two clock edges later. `tx_sof` is 1 on that byte only. The packet length is taken from `cfg_pkt_len` at that edge. Later changes to `cfg_pkt_len` do not affect the packet already open.
- R4: Packet bytes 0 to 7 are 0x55, 0x55, 0x55, 0xD5, `src_node[15:8]`, `src_node[7:0]`, `dst_node[15:8]`, `dst_node[7:0]`. Both addresses are sampled at the edge that opens the packet.
- R5: Bytes 8 to L-5 form the payload region, where L is the packet length. Each position of the region carries the next accepted payload byte, in order of acceptance. A byte is accepted when `pl_valid` and `pl_ready` are both 1 at a clock edge.
- R6: `pl_ready` is 1 only inside the payload region, and only until a byte with `pl_last`=1 has been accepted. Bytes still offered when the region is full stay pending and are taken by the next packet.
- R7: A payload position where no byte is accepted carries 0xAA. This happens after the last byte has been accepted, and also when `pl_valid` is low.
- R8: The last four bytes hold the CRC-32 over packet bytes 4 to L-5, fill bytes included. The CRC uses the reflected polynomial 0xEDB88320, bits LSB first, an initial value of all ones and a complemented result. The CRC is sent least significant byte first.
- R9: A `cfg_pkt_len` of 12 or less gives a 12-byte packet with no payload region, and no byte is accepted.
- R10: A `slot_start` sampled while `busy` is 1 is ignored and adds one to `start_err_cnt`, which stops at its all-ones value. `busy` falls at the edge that sends the last CRC byte, so a start in the following cycle is accepted, leaving exactly one 0xAA byte between the two packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pkt_len | input | LEN_W | Total packet length in bytes, read when a packet opens |
| slot_start | input | 1 | Slot pulse that opens a packet |
| src_node | input | 16 | Source node address |
| dst_node | input | 16 | Destination node address |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte offered |
| pl_last | input | 1 | Offered byte is the last of the data |
| pl_ready | output | 1 | Framer takes a payload byte this cycle |
| tx_data | output | 8 | Line byte, one per cycle |
| tx_sof | output | 1 | Marks the first byte of a packet on `tx_data` |
| busy | output | 1 | A packet is being sequenced |
| start_err_cnt | output | ERR_W | Saturating count of ignored slot starts |

## Verification
Two collisions are provoked on purpose. In the first, a new slot pulse arrives one cycle before the packet's final CRC byte leaves the line and is held for one more cycle. The bench expects the first cycle to be counted as an ignored start. It expects the second cycle to open a packet after exactly one fill byte. In the second, the end-of-data flag arrives on the very byte that fills the payload region. The bench expects the trailer to follow at once and no later byte to be taken. Every packet is rebuilt in the bench from the stimulus it drove, including the CRC. Packet lengths and payload counts are swept, with and without valid stalls.

// File: rtl/framer_pkg.sv
// framer_pkg: shared constants, state type and CRC step for the slotted framer.
// Assumes byte-wide data and a 16-bit node address per side.
package framer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_ADR,
        ST_PAY,
        ST_FCS
    } fr_state_t;

    localparam int          NODE_W         = 16;
    localparam int          PRE_BYTES      = 3;
    localparam int          ADR_BYTES      = 4;
    localparam int          FCS_BYTES      = 4;
    localparam int          OVERHEAD_BYTES = PRE_BYTES + 1 + ADR_BYTES + FCS_BYTES;
    localparam logic [7:0]  PRE_BYTE       = 8'h55;
    localparam logic [7:0]  SFD_BYTE       = 8'hD5;
    localparam logic [7:0]  FILL_BYTE      = 8'hAA;
    localparam logic [31:0] CRC_POLY_REF   = 32'hEDB88320;

    // Advance a reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            r = (r[0] ^ d[b]) ? ((r >> 1) ^ CRC_POLY_REF) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/framer_seq.sv
// framer_seq: field sequencer. Walks preamble, delimiter, address, payload
// region and CRC trailer, one byte per cycle, after an accepted slot start.
// Assumes cfg_pkt_len is only read at the accepting edge; short lengths clamp.
module framer_seq
    import framer_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    input  logic [LEN_W-1:0] cfg_pkt_len,
    output fr_state_t        state,
    output logic [1:0]       sub,
    output logic             start_ok,
    output logic             start_drop,
    output logic             first_byte
);

    localparam logic [LEN_W-1:0] OVH     = LEN_W'(OVERHEAD_BYTES);
    localparam logic [LEN_W-1:0] PRE_END = LEN_W'(PRE_BYTES - 1);
    localparam logic [LEN_W-1:0] ADR_END = LEN_W'(ADR_BYTES - 1);
    localparam logic [LEN_W-1:0] FCS_END = LEN_W'(FCS_BYTES - 1);

    fr_state_t        state_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] plen_q;
    logic [LEN_W-1:0] plen_next;
    logic             field_end;
    fr_state_t        next_field;

    assign state      = state_q;
    assign sub        = idx_q[1:0];
    assign start_ok   = slot_start && (state_q == ST_IDLE);
    assign start_drop = slot_start && (state_q != ST_IDLE);
    assign first_byte = (state_q == ST_PRE) && (idx_q == '0);
    assign plen_next  = (cfg_pkt_len > OVH) ? (cfg_pkt_len - OVH) : '0;

    // Decide whether the current byte closes its field and which field follows.
    always_comb begin
        field_end  = 1'b0;
        next_field = ST_IDLE;
        case (state_q)
            ST_PRE: begin field_end = (idx_q == PRE_END); next_field = ST_SFD; end
            ST_SFD: begin field_end = 1'b1;               next_field = ST_ADR; end
            ST_ADR: begin
                field_end  = (idx_q == ADR_END);
                next_field = (plen_q == '0) ? ST_FCS : ST_PAY;
            end
            ST_PAY: begin field_end = (idx_q == plen_q - 1'b1); next_field = ST_FCS; end
            ST_FCS: begin field_end = (idx_q == FCS_END);       next_field = ST_IDLE; end
            default: begin field_end = 1'b0; next_field = ST_IDLE; end
        endcase
    end

    // Advance the field state and byte index; latch the payload size on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            plen_q  <= '0;
        end else if (start_ok) begin
            state_q <= ST_PRE;
            idx_q   <= '0;
            plen_q  <= plen_next;
        end else if (state_q != ST_IDLE) begin
            if (field_end) begin
                state_q <= next_field;
                idx_q   <= '0;
            end else begin
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/framer_crc32.sv
// framer_crc32: byte-serial reflected CRC-32 accumulator.
// Assumes init and en are never both needed in one cycle; init wins.
module framer_crc32
    import framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);

    logic [31:0] crc_q;

    assign crc_out = ~crc_q;

    // Preset on packet open, fold in each covered byte.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

endmodule

// File: rtl/framer_sat_cnt.sv
// framer_sat_cnt: up counter that holds at its all-ones value.
// Assumes one increment per cycle at most.
module framer_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count events until the top value is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pkt_framer.sv
// pkt_framer: slotted packet framer. Emits one byte per cycle: fill 0xAA
// between packets, and preamble, delimiter, address, payload (fill where no
// data) and CRC-32 inside a packet. Assumes the payload source honours
// valid/ready and that slot pulses are synchronous to clk.
module pkt_framer
    import framer_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_pkt_len,
    input  logic              slot_start,
    input  logic [NODE_W-1:0] src_node,
    input  logic [NODE_W-1:0] dst_node,
    input  logic [7:0]        pl_data,
    input  logic              pl_valid,
    input  logic              pl_last,
    output logic              pl_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              busy,
    output logic [ERR_W-1:0]  start_err_cnt
);

    fr_state_t         state;
    logic [1:0]        sub;
    logic              start_ok;
    logic              start_drop;
    logic              first_byte;
    logic [NODE_W-1:0] src_q;
    logic [NODE_W-1:0] dst_q;
    logic              ended_q;
    logic [7:0]        byte_sel;
    logic [31:0]       crc_val;
    logic              take;

    framer_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .cfg_pkt_len(cfg_pkt_len),
        .state      (state),
        .sub        (sub),
        .start_ok   (start_ok),
        .start_drop (start_drop),
        .first_byte (first_byte)
    );

    framer_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (start_ok),
        .en     ((state == ST_ADR) || (state == ST_PAY)),
        .din    (byte_sel),
        .crc_out(crc_val)
    );

    framer_sat_cnt #(.W(ERR_W)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (start_drop),
        .count(start_err_cnt)
    );

    assign busy     = (state != ST_IDLE);
    assign pl_ready = (state == ST_PAY) && !ended_q;
    assign take     = pl_ready && pl_valid;

    // Capture the address pair when a packet opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (start_ok) begin
            src_q <= src_node;
            dst_q <= dst_node;
        end
    end

    // Remember that the end-of-data byte has been taken in this packet.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            ended_q <= 1'b0;
        end else if (take && pl_last) begin
            ended_q <= 1'b1;
        end
    end

    // Choose the byte for the current field position.
    always_comb begin
        byte_sel = FILL_BYTE;
        case (state)
            ST_PRE: byte_sel = PRE_BYTE;
            ST_SFD: byte_sel = SFD_BYTE;
            ST_ADR: begin
                case (sub)
                    2'd0:    byte_sel = src_q[15:8];
                    2'd1:    byte_sel = src_q[7:0];
                    2'd2:    byte_sel = dst_q[15:8];
                    default: byte_sel = dst_q[7:0];
                endcase
            end
            ST_PAY: byte_sel = take ? pl_data : FILL_BYTE;
            ST_FCS: byte_sel = 8'(crc_val >> {sub, 3'b000});
            default: byte_sel = FILL_BYTE;
        endcase
    end

    // Register the line byte and the start-of-packet marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= FILL_BYTE;
            tx_sof  <= 1'b0;
        end else begin
            tx_data <= byte_sel;
            tx_sof  <= first_byte;
        end
    end

endmodule

// File: rtl/framer_checker.sv
// framer_checker: temporal properties of pkt_framer at its ports.
// Assumes a synchronous active-low reset.
module framer_checker #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_start,
    input logic             pl_ready,
    input logic             busy,
    input logic [7:0]       tx_data,
    input logic             tx_sof,
    input logic [ERR_W-1:0] start_err_cnt
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    assert_gap_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (tx_data == 8'hAA));

    assert_sof_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> $past(slot_start, 2));

    assert_sof_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> (tx_data == 8'h55));

    assert_ready_in_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> busy);

    assert_drop_counted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slot_start && (start_err_cnt != ERR_MAX))
            |=> (start_err_cnt == $past(start_err_cnt) + 1'b1));

    assert_err_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (start_err_cnt >= $past(start_err_cnt)));

endmodule

bind pkt_framer framer_checker #(.ERR_W(ERR_W)) i_framer_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_start   (slot_start),
    .pl_ready     (pl_ready),
    .busy         (busy),
    .tx_data      (tx_data),
    .tx_sof       (tx_sof),
    .start_err_cnt(start_err_cnt)
);

// File: tb/test_pkt_framer.sv
`timescale 1ns/100ps
// test_pkt_framer: sweeps packet lengths and payload counts, rebuilding each
// packet and its CRC in the bench from the driven stimulus.
module test_pkt_framer;

    localparam int LEN_W = 16;
    localparam int ERR_W = 8;
    localparam int ERR_TOP = 255;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] cfg_pkt_len = 16'd20;
    logic             slot_start = 1'b0;
    logic [15:0]      src_node = 16'h0000;
    logic [15:0]      dst_node = 16'h0000;
    logic [7:0]       pl_data = 8'h00;
    logic             pl_valid = 1'b0;
    logic             pl_last = 1'b0;
    logic             pl_ready;
    logic [7:0]       tx_data;
    logic             tx_sof;
    logic             busy;
    logic [ERR_W-1:0] start_err_cnt;

    int checks = 0;
    int fails = 0;
    int ptr = 0;
    int src_end = 0;
    int last_idx = -1;
    bit stall_en = 1'b0;
    bit hs = 1'b0;
    int cyc = 0;
    int exp_err = 0;
    logic [7:0] cap [0:319];
    logic       sofv [0:319];

    pkt_framer #(.LEN_W(LEN_W), .ERR_W(ERR_W)) i_pkt_framer (
        .clk(clk), .rst_n(rst_n), .cfg_pkt_len(cfg_pkt_len), .slot_start(slot_start),
        .src_node(src_node), .dst_node(dst_node), .pl_data(pl_data), .pl_valid(pl_valid),
        .pl_last(pl_last), .pl_ready(pl_ready), .tx_data(tx_data), .tx_sof(tx_sof),
        .busy(busy), .start_err_cnt(start_err_cnt)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pb(input int i);
        return 8'((i * 37 + 11) % 160 + 1);
    endfunction

    // Payload source: count the previous handshake, then offer the next byte.
    always @(negedge clk) begin
        if (hs) ptr = ptr + 1;
        cyc = cyc + 1;
        pl_valid = (ptr < src_end) && !(stall_en && (cyc % 3 == 0));
        pl_data  = pb(ptr);
        pl_last  = (ptr == last_idx);
        #1 hs = pl_valid && pl_ready;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bench_crc(input int lo, input int hi);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = lo; i <= hi; i++) begin
            for (int b = 0; b < 8; b++) begin
                if ((c[0] ^ cap[i][b]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
                else c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic set_src(input int np, input int nlast);
        src_end  = ptr + np;
        last_idx = (nlast > 0) ? ptr + nlast - 1 : -1;
    endtask

    task automatic kick();
        @(negedge clk) slot_start = 1'b1;
        @(negedge clk) slot_start = 1'b0;
    endtask

    task automatic grab(input int len, input int inj_lo, input int inj_hi);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cap[i]  = tx_data;
            sofv[i] = tx_sof;
            slot_start = (i >= inj_lo) && (i <= inj_hi);
        end
    endtask

    task automatic gap_check();
        @(negedge clk) slot_start = 1'b0;
        chk(tx_data == 8'hAA && !tx_sof && !busy, "R2", "gap byte", {24'h0, tx_data}, 32'hAA);
    endtask

    // Compare a captured packet with one rebuilt from the requirements.
    task automatic verify(input int len, input logic [15:0] s, input logic [15:0] d,
                          input int base, input int navail, input bit exact);
        int plen, nacc, bad, n;
        logic [7:0] hdr [0:7];
        logic [31:0] act, exp;
        plen = len - 12;
        bad = (sofv[0] !== 1'b1) ? 1 : 0;
        for (int i = 1; i < len; i++) if (sofv[i] !== 1'b0) bad++;
        chk(bad == 0, "R3", "tx_sof placement", bad, 0);
        hdr = '{8'h55, 8'h55, 8'h55, 8'hD5, s[15:8], s[7:0], d[15:8], d[7:0]};
        bad = 0;
        for (int i = 0; i < 8; i++) if (cap[i] !== hdr[i]) bad++;
        chk(bad == 0, "R4", "header bytes", {24'h0, cap[4]}, {24'h0, s[15:8]});
        if (exact) begin
            nacc = (navail < plen) ? navail : plen;
            bad = 0;
            for (int j = 0; j < nacc; j++) if (cap[8+j] !== pb(base + j)) bad++;
            chk(bad == 0, "R5", "payload bytes", bad, 0);
            bad = 0;
            for (int j = nacc; j < plen; j++) if (cap[8+j] !== 8'hAA) bad++;
            chk(bad == 0, "R7", "fill after data", bad, 0);
            chk(ptr - base == nacc, "R6", "bytes accepted", ptr - base, nacc);
        end else begin
            n = 0; bad = 0;
            for (int j = 0; j < plen; j++) begin
                if (cap[8+j] !== 8'hAA) begin
                    if (cap[8+j] !== pb(base + n)) bad++;
                    n++;
                end
            end
            chk(bad == 0, "R5", "stalled payload order", bad, 0);
            chk(ptr - base == n, "R7", "stall positions filled", ptr - base, n);
        end
        act = {cap[len-1], cap[len-2], cap[len-3], cap[len-4]};
        exp = bench_crc(4, len - 5);
        chk(act == exp, "R8", "crc trailer", act, exp);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(tx_data == 8'hAA && !tx_sof && !pl_ready && !busy && start_err_cnt == 0,
            "R1", "in reset", {24'h0, tx_data}, 32'hAA);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_data == 8'hAA && !tx_sof && !pl_ready && !busy && start_err_cnt == 0,
            "R1", "after reset", {24'h0, tx_data}, 32'hAA);
        begin
            int bad = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (tx_data !== 8'hAA || tx_sof || busy) bad++;
            end
            chk(bad == 0, "R2", "idle line fill", bad, 0);
        end

        // Payload exactly fills the region, last flag on the final position.
        src_node = 16'h1234; dst_node = 16'hABCD; cfg_pkt_len = 20;
        base = ptr; set_src(8, 8);
        kick(); grab(20, -1, -1); verify(20, 16'h1234, 16'hABCD, base, 8, 1); gap_check();

        // Last flag early with more data offered: ready must drop (R6, R7).
        base = ptr; set_src(10, 3); src_node = 16'h0F0E; dst_node = 16'h0001;
        kick(); grab(20, -1, -1); verify(20, 16'h0F0E, 16'h0001, base, 3, 1); gap_check();

        // More data than the region holds: the rest waits for the next packet.
        base = ptr; set_src(12, 12);
        kick(); grab(20, -1, -1); verify(20, 16'h0F0E, 16'h0001, base, 8, 1);
        @(negedge clk); #2;
        chk(pl_valid && !pl_ready, "R6", "ready low in gap", {31'h0, pl_ready}, 0);
        base = ptr;
        kick(); grab(20, -1, -1); verify(20, 16'h0F0E, 16'h0001, base, 4, 1); gap_check();

        // Length of exactly the overhead and below it (R9).
        base = ptr; set_src(3, 3); cfg_pkt_len = 12;
        kick(); grab(12, -1, -1); verify(12, 16'h0F0E, 16'h0001, base, 0, 1); gap_check();
        chk(ptr == base, "R9", "no byte taken len 12", ptr - base, 0);
        cfg_pkt_len = 5;
        kick(); grab(12, -1, -1); verify(12, 16'h0F0E, 16'h0001, base, 0, 1); gap_check();
        chk(ptr == base, "R9", "no byte taken len 5", ptr - base, 0);

        // Starts during a packet are ignored and counted (R10).
        base = ptr; set_src(2, 2); cfg_pkt_len = 24;
        kick(); grab(24, 5, 7); exp_err += 3;
        verify(24, 16'h0F0E, 16'h0001, base, 2, 1); gap_check();
        chk(start_err_cnt == exp_err, "R10", "ignored start count", start_err_cnt, exp_err);

        // Length changed after the packet opened has no effect (R3).
        base = ptr; set_src(5, 5); cfg_pkt_len = 20;
        kick(); cfg_pkt_len = 40; src_node = 16'h7777;
        grab(20, -1, -1); verify(20, 16'h0F0E, 16'h0001, base, 5, 1); gap_check();

        // Start one cycle before and at the final trailer byte (R10).
        base = ptr; set_src(4, 4); cfg_pkt_len = 16; src_node = 16'h2468; dst_node = 16'h1357;
        kick(); cfg_pkt_len = 16; grab(16, 14, 15); exp_err += 1;
        verify(16, 16'h2468, 16'h1357, base, 4, 1);
        @(negedge clk) slot_start = 1'b0;
        chk(tx_data == 8'hAA && !tx_sof, "R10", "single fill byte between packets",
            {24'h0, tx_data}, 32'hAA);
        base = ptr;
        grab(16, -1, -1); verify(16, 16'h2468, 16'h1357, base, 0, 1); gap_check();
        chk(start_err_cnt == exp_err, "R10", "back-to-back count", start_err_cnt, exp_err);

        // Sweep lengths and payload counts, odd counts with valid stalls.
        for (int len = 12; len <= 30; len++) begin
            for (int np = 0; np <= len - 11; np++) begin
                base = ptr; set_src(np, np); cfg_pkt_len = 16'(len);
                src_node = 16'(len * 257); dst_node = 16'(np * 4099 + 3);
                stall_en = (np % 2) == 1;
                kick(); grab(len, -1, -1);
                verify(len, 16'(len * 257), 16'(np * 4099 + 3), base, np, !stall_en);
                stall_en = 1'b0;
                gap_check();
            end
        end

        // Long packet with start held high: the counter saturates (R10).
        base = ptr; set_src(0, 0); cfg_pkt_len = 300;
        kick(); grab(300, 0, 297);
        exp_err = (exp_err + 298 > ERR_TOP) ? ERR_TOP : exp_err + 298;
        verify(300, 16'(30 * 257), 16'(19 * 4099 + 3), base, 0, 1); gap_check();
        chk(start_err_cnt == exp_err, "R10", "saturated count", start_err_cnt, exp_err);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule